// File: doc/BRIEF.md
# Counted Loop Branch Unit

This block resolves a counted loop branch in a simple processor datapath. On a request cycle it takes one of three loop operation codes together with the present count register value, the zero flag, the sequential next-instruction address and the branch target. It reduces the count by one, decides whether the branch is taken and selects the address that fetch should use next. All results leave through registers, one cycle after the request.

The plain loop branches while the reduced count is not zero. Two qualified loops also need the zero flag: one branches only while the flag is set, the other only while it is clear. The "while zero" and "while not zero" forms share these two encodings. The unit never writes the status flags, and it has no flag output. A count of zero wraps to all ones, so the loop then runs 2^32 times.

Top module: `loop_branch_unit`

## Requirements
- R1: While reset is asserted, and after it is released, out_valid, cnt_we and taken are 0, and cnt_out and next_addr are 0.
- R2: A request with req_valid=1 and an operation code other than 2'b11 raises out_valid and cnt_we for exactly the cycle after the clock edge that accepts it. Without an accepted request, both are 0.
- R3: For every accepted request, cnt_out equals cnt_in minus one, modulo 2^32.
- R4: The plain loop (req_op=2'b00) is taken exactly when the reduced count is nonzero. The zero flag has no effect on it.
- R5: The loop-while-equal code (req_op=2'b01, also used for loop-while-zero) is taken exactly when zf_in=1 and the reduced count is nonzero.
- R6: The loop-while-not-equal code (req_op=2'b10, also used for loop-while-not-zero) is taken exactly when zf_in=0 and the reduced count is nonzero.
- R7: For an accepted request, next_addr is tgt_addr when the branch is taken and seq_addr when it is not.
- R8: A count of 0 with the plain loop gives cnt_out=32'hFFFF_FFFF, and the branch is taken.
- R9: The reserved code 2'b11 is ignored. out_valid and cnt_we stay 0, and cnt_out and next_addr keep their earlier values.
- R10: When cnt_out is fed back as cnt_in for each plain loop pass, a starting count of 5 gives exactly 5 passes: 4 taken decisions, then one not taken.
- R11: taken is 0 in any cycle where out_valid is 0. cnt_out and next_addr hold their values in cycles without an accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | Loop code: 00 plain, 01 while equal/zero, 10 while not equal/zero, 11 reserved |
| cnt_in | input | 32 | Present count register value |
| zf_in | input | 1 | Present zero flag |
| seq_addr | input | 32 | Sequential next-instruction address |
| tgt_addr | input | 32 | Branch target address |
| out_valid | output | 1 | Result strobe, one cycle after acceptance |
| cnt_out | output | 32 | Reduced count |
| cnt_we | output | 1 | Count register write enable |
| taken | output | 1 | Branch taken |
| next_addr | output | 32 | Selected next address |

## Verification
A table of requests drives each loop code with the zero flag set and clear. The counts used are 1, which reduces to zero, and larger values that do not. The 1 cases separate the count-exhausted exit from the flag-driven exit. Setting the flag the "wrong" way for each qualified code shows that the flag test and the count test are joined by AND and not by OR. A count of 0 and counts with the top bit set check the wrap and the full-width zero detect. Directed tests cover reset values, the ignored reserved code with its held outputs, and a five-pass loop where cnt_out is fed back into cnt_in.

// File: rtl/lb_pkg.sv
package lb_pkg;
  localparam int unsigned LB_CNT_W  = 32;
  localparam int unsigned LB_ADDR_W = 32;
  localparam int unsigned LB_OP_W   = 2;

  typedef enum logic [LB_OP_W-1:0] {
    LB_PLAIN    = 2'b00,
    LB_WHILE_EQ = 2'b01,
    LB_WHILE_NE = 2'b10,
    LB_RSVD     = 2'b11
  } lb_op_e;
endpackage

// File: rtl/lb_decr.sv
module lb_decr #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] cnt_i,
  output logic [W-1:0] dec_o,
  output logic         dec_nz_o
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  always_comb begin
    dec_o    = cnt_i - ONE;
    dec_nz_o = |dec_o;
  end
endmodule

// File: rtl/lb_cond.sv
module lb_cond
  import lb_pkg::*;
(
  input  logic       req_valid_i,
  input  lb_op_e     op_i,
  input  logic       zf_i,
  input  logic       dec_nz_i,
  output logic       accept_o,
  output logic       taken_o
);
  logic flag_ok;

  always_comb begin
    unique case (op_i)
      LB_PLAIN:    flag_ok = 1'b1;
      LB_WHILE_EQ: flag_ok = zf_i;
      LB_WHILE_NE: flag_ok = ~zf_i;
      default:     flag_ok = 1'b0;
    endcase
    accept_o = req_valid_i && (op_i != LB_RSVD);
    taken_o  = accept_o && flag_ok && dec_nz_i;
  end
endmodule

// File: rtl/lb_pipe.sv
module lb_pipe #(
  parameter int unsigned CW = 32,
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept_i,
  input  logic          taken_i,
  input  logic [CW-1:0] dec_i,
  input  logic [AW-1:0] seq_i,
  input  logic [AW-1:0] tgt_i,
  output logic          valid_o,
  output logic          taken_o,
  output logic [CW-1:0] cnt_o,
  output logic [AW-1:0] addr_o
);
  logic          valid_d, taken_d;
  logic [CW-1:0] cnt_d;
  logic [AW-1:0] addr_d;

  always_comb begin
    valid_d = accept_i;
    taken_d = taken_i;
    cnt_d   = cnt_o;
    addr_d  = addr_o;
    if (accept_i) begin
      cnt_d  = dec_i;
      addr_d = taken_i ? tgt_i : seq_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      taken_o <= 1'b0;
      cnt_o   <= '0;
      addr_o  <= '0;
    end else begin
      valid_o <= valid_d;
      taken_o <= taken_d;
      if (accept_i) begin
        cnt_o  <= cnt_d;
        addr_o <= addr_d;
      end
    end
  end
endmodule

// File: rtl/loop_branch_unit.sv
module loop_branch_unit
  import lb_pkg::*;
#(
  parameter int unsigned CNT_W  = LB_CNT_W,
  parameter int unsigned ADDR_W = LB_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [CNT_W-1:0]  cnt_in,
  input  logic              zf_in,
  input  logic [ADDR_W-1:0] seq_addr,
  input  logic [ADDR_W-1:0] tgt_addr,
  output logic              out_valid,
  output logic [CNT_W-1:0]  cnt_out,
  output logic              cnt_we,
  output logic              taken,
  output logic [ADDR_W-1:0] next_addr
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [CNT_W-1:0] dec;
  logic             dec_nz, accept, taken_c;
  lb_op_e           op;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];
  assign op        = lb_op_e'(req_op);

  lb_decr #(.W(CNT_W)) u_decr (
    .cnt_i    (cnt_in),
    .dec_o    (dec),
    .dec_nz_o (dec_nz)
  );

  lb_cond u_cond (
    .req_valid_i (req_valid),
    .op_i        (op),
    .zf_i        (zf_in),
    .dec_nz_i    (dec_nz),
    .accept_o    (accept),
    .taken_o     (taken_c)
  );

  lb_pipe #(.CW(CNT_W), .AW(ADDR_W)) u_pipe (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .accept_i (accept),
    .taken_i  (taken_c),
    .dec_i    (dec),
    .seq_i    (seq_addr),
    .tgt_i    (tgt_addr),
    .valid_o  (out_valid),
    .taken_o  (taken),
    .cnt_o    (cnt_out),
    .addr_o   (next_addr)
  );

  assign cnt_we = out_valid;
endmodule

// File: rtl/lb_checker.sv
module lb_checker #(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [1:0]        req_op,
  input logic [CNT_W-1:0]  cnt_in,
  input logic              zf_in,
  input logic [ADDR_W-1:0] seq_addr,
  input logic [ADDR_W-1:0] tgt_addr,
  input logic              out_valid,
  input logic [CNT_W-1:0]  cnt_out,
  input logic              cnt_we,
  input logic              taken,
  input logic [ADDR_W-1:0] next_addr
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};
  logic acc;
  assign acc = req_valid && (req_op != 2'b11);

  p_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (out_valid && cnt_we));
  p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> (!out_valid && !cnt_we));
  p_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (cnt_out == $past(cnt_in) - ONE));
  p_plain_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_op == 2'b00) |=> (taken == ($past(cnt_in) != ONE)));
  p_while_eq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_op == 2'b01) |=> (taken == ($past(zf_in) && ($past(cnt_in) != ONE))));
  p_while_ne_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_op == 2'b10) |=> (taken == (!$past(zf_in) && ($past(cnt_in) != ONE))));
  p_addr_sel_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (next_addr == (taken ? $past(tgt_addr) : $past(seq_addr))));
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> ($stable(cnt_out) && $stable(next_addr)));
  p_quiet_taken_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !taken);
endmodule

bind loop_branch_unit lb_checker #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .req_valid (req_valid),
  .req_op    (req_op),
  .cnt_in    (cnt_in),
  .zf_in     (zf_in),
  .seq_addr  (seq_addr),
  .tgt_addr  (tgt_addr),
  .out_valid (out_valid),
  .cnt_out   (cnt_out),
  .cnt_we    (cnt_we),
  .taken     (taken),
  .next_addr (next_addr)
);

// File: tb/tb_loop_branch_unit.sv
`timescale 1ns/1ps
module tb_loop_branch_unit;
  logic        clk, rst_n, req_valid, zf_in;
  logic [1:0]  req_op;
  logic [31:0] cnt_in, seq_addr, tgt_addr;
  logic        out_valid, cnt_we, taken;
  logic [31:0] cnt_out, next_addr;

  int checks, errors;
  bit done;

  loop_branch_unit dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .cnt_in(cnt_in), .zf_in(zf_in), .seq_addr(seq_addr), .tgt_addr(tgt_addr),
    .out_valid(out_valid), .cnt_out(cnt_out), .cnt_we(cnt_we),
    .taken(taken), .next_addr(next_addr)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // {op[1:0], zf, count[31:0], expected taken}
  localparam int NV = 12;
  localparam logic [35:0] VEC [NV] = '{
    {2'b00, 1'b0, 32'd5,          1'b1},
    {2'b00, 1'b1, 32'd1,          1'b0},
    {2'b00, 1'b0, 32'd0,          1'b1},
    {2'b01, 1'b1, 32'd3,          1'b1},
    {2'b01, 1'b0, 32'd3,          1'b0},
    {2'b01, 1'b1, 32'd1,          1'b0},
    {2'b10, 1'b0, 32'd7,          1'b1},
    {2'b10, 1'b1, 32'd7,          1'b0},
    {2'b10, 1'b0, 32'd1,          1'b0},
    {2'b00, 1'b1, 32'h8000_0000,  1'b1},
    {2'b01, 1'b1, 32'hFFFF_FFFF,  1'b1},
    {2'b10, 1'b0, 32'd2,          1'b1}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one request at a falling edge, return after the following falling edge
  task automatic issue(input logic [1:0] op, input logic zf, input logic [31:0] cnt,
                       input logic [31:0] sq, input logic [31:0] tg);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; zf_in = zf; cnt_in = cnt; seq_addr = sq; tgt_addr = tg;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  function automatic string tag_for(input logic [1:0] op);
    case (op)
      2'b00:   return "R4";
      2'b01:   return "R5";
      default: return "R6";
    endcase
  endfunction

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] held_cnt, held_addr, c;
    int passes;
    checks = 0; errors = 0; done = 1'b0;
    rst_n = 1'b0; req_valid = 1'b0; req_op = 2'b00; zf_in = 1'b0;
    cnt_in = '0; seq_addr = '0; tgt_addr = '0;
    repeat (3) @(negedge clk);
    // R1: reset values
    check(out_valid == 1'b0 && cnt_we == 1'b0 && taken == 1'b0, "R1 strobes", {29'd0, out_valid, cnt_we, taken}, 32'd0);
    check(cnt_out == 32'd0, "R1 cnt_out", cnt_out, 32'd0);
    check(next_addr == 32'd0, "R1 next_addr", next_addr, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(out_valid == 1'b0 && taken == 1'b0, "R1 after release", {30'd0, out_valid, taken}, 32'd0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic [1:0]  op;
      logic        zf, et;
      logic [31:0] cn, sq, tg, ea;
      {op, zf, cn, et} = VEC[i];
      sq = 32'h0000_1000 + 32'(i) * 4;
      tg = 32'h2000_0000 ^ (32'(i) * 16);
      ea = et ? tg : sq;
      issue(op, zf, cn, sq, tg);
      check(out_valid && cnt_we, "R2 strobe", {30'd0, out_valid, cnt_we}, 32'd3);
      check(cnt_out == cn - 32'd1, "R3 count", cnt_out, cn - 32'd1);
      check(taken == et, tag_for(op), {31'd0, taken}, {31'd0, et});
      check(next_addr == ea, "R7 next_addr", next_addr, ea);
      if (cn == 32'd0)
        check(cnt_out == 32'hFFFF_FFFF && taken, "R8 wrap", cnt_out, 32'hFFFF_FFFF);
      @(negedge clk);
      check(!out_valid && !cnt_we && !taken, "R2 R11 strobe drops", {29'd0, out_valid, cnt_we, taken}, 32'd0);
      check(cnt_out == cn - 32'd1 && next_addr == ea, "R11 hold", next_addr, ea);
    end

    // R9: reserved code ignored
    held_cnt = cnt_out; held_addr = next_addr;
    issue(2'b11, 1'b1, 32'd9, 32'hAAAA_0000, 32'hBBBB_0000);
    check(!out_valid && !cnt_we && !taken, "R9 no strobe", {29'd0, out_valid, cnt_we, taken}, 32'd0);
    check(cnt_out == held_cnt, "R9 count held", cnt_out, held_cnt);
    check(next_addr == held_addr, "R9 addr held", next_addr, held_addr);

    // R10: five passes from a count of 5
    c = 32'd5; passes = 1;
    for (int k = 0; k < 10; k++) begin
      issue(2'b00, 1'b0, c, 32'h0000_0400, 32'h0000_0100);
      if (!taken) break;
      passes++;
      c = cnt_out;
    end
    check(passes == 5, "R10 passes", 32'(passes), 32'd5);
    check(cnt_out == 32'd0 && next_addr == 32'h0000_0400, "R10 exit state", cnt_out, 32'd0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule